// File: doc/BRIEF.md
# Write-Back Three-State Snooping Cache Controller

This block keeps one small direct-mapped write-back cache coherent with its peers on a shared, atomic snooping bus. Each line holds a tag, one data word and a coherence state: Invalid, Shared (clean, read-only) or Exclusive (the single copy, writable and dirty). The processor side presents a request and holds it until `cpu_ready`. Hits complete at once. Misses become bus requests: a read miss, a write miss, or a write-back of a dirty victim.

Bus ownership uses a request/grant pair. A transaction completes in the single cycle in which `bus_gnt` is high, and the fill word arrives on `bus_fill` in that same cycle. The controller writes the line only when the grant arrives. While a request is pending, the controller re-evaluates it every cycle from the live line state, so a snoop that changes the line restarts the request in its new form.

The snoop side watches the other agents' transactions. When another agent misses on a line held Exclusive, the controller drives the dirty word and a flush strobe in the same cycle. This tells the memory to abandon its own reply. The line then drops to Shared after a foreign read miss, or to Invalid after a foreign write miss.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. No snoop produces a flush, and the first access to any address needs the bus.
- R2: A processor read that misses places a read miss (bus command code 1) carrying the processor address. On grant, the line becomes Shared with the fill word, and the held read completes in the next cycle with that word.
- R3: A processor write to an Invalid or Shared line places a write miss (code 2). On grant, the line becomes Exclusive, and the held write then completes as a hit in the next cycle.
- R4: A read hit on a Shared or Exclusive line, and a write hit on an Exclusive line, raise `cpu_ready` in the request cycle with no bus request. A read hit returns the last word written.
- R5: A miss whose index holds an Exclusive line with a different tag first requests a write-back (code 3) carrying the victim's address and data. After that grant, it requests the read or write miss.
- R6: A foreign write miss that matches a Shared line makes it Invalid. A foreign read miss that matches a Shared line leaves it Shared. Neither produces a flush.
- R7: A foreign read miss that matches an Exclusive line raises `snp_flush` with the line's data in that cycle and leaves the line Shared.
- R8: A foreign write miss that matches an Exclusive line raises `snp_flush` with the line's data and leaves the line Invalid.
- R9: Snooped transactions are ignored when they carry this agent's own id, when they are write-backs, or when their tag does not match the line.
- R10: When a snoop hits the index of the processor access in the same cycle, the processor does not complete in that cycle. The snoop is applied first, and the pending request is rebuilt from the new state. For example, a pending write-back becomes a plain read miss once a flush has cleaned the victim.
- R11: A miss keeps `bus_req` high and `cpu_ready` low until the grant. The line is not changed before the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access pending, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address: low bits index, high bits tag |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ready |
| bus_req | output | 1 | Bus transaction wanted |
| bus_gnt | input | 1 | Bus granted; transaction completes this cycle |
| bus_cmd | output | 2 | 0 none, 1 read miss, 2 write miss, 3 write-back |
| bus_addr | output | ADDR_W | Address of own transaction |
| bus_wdata | output | DATA_W | Victim data for a write-back |
| bus_fill | input | DATA_W | Fill word delivered with the grant |
| snp_valid | input | 1 | A bus transaction is visible to the snooper |
| snp_cmd | input | 2 | Snooped command, same coding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_agent | input | AGENT_W | Id of the agent that issued the snooped transaction |
| snp_flush | output | 1 | Supplying dirty data; memory reply is cancelled |
| snp_data | output | DATA_W | Dirty word supplied with snp_flush |

## Verification
Two functions can meet in a single cycle: a local hit and a foreign snoop on the same index, or a pending miss and a foreign snoop that rewrites the victim. The bench provokes the first case by presenting a read of an Exclusive line in the same cycle as a foreign read miss to it. It expects no completion and a flush in that cycle, the read in the next cycle, and a write miss on a later write, which shows the line fell to Shared. For the second case, the bench holds a write-back request ungranted and injects a foreign read miss on the victim. It then requires the pending command to change from write-back to read miss before it grants.

// File: rtl/msi_snoop_pkg.sv
package msi_snoop_pkg;

  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_EXC = 2'd2
  } line_st_t;

  typedef enum logic [1:0] {
    BC_NONE   = 2'd0,
    BC_RDMISS = 2'd1,
    BC_WRMISS = 2'd2,
    BC_WRBACK = 2'd3
  } bus_cmd_t;

endpackage

// File: rtl/msi_rst_sync.sv
module msi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_snoop_pkg::*;
#(
  parameter int NLINES = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(NLINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output line_st_t          a_st,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output line_st_t          b_st,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic              sw_en,
  input  logic [IDX_W-1:0]  sw_idx,
  input  line_st_t          sw_st,
  input  logic              cw_en,
  input  logic [IDX_W-1:0]  cw_idx,
  input  line_st_t          cw_st,
  input  logic              cw_tag_en,
  input  logic [TAG_W-1:0]  cw_tag,
  input  logic              cw_data_en,
  input  logic [DATA_W-1:0] cw_data
);
  logic [NLINES-1:0][1:0]        st_arr;
  logic [NLINES-1:0][TAG_W-1:0]  tag_arr;
  logic [NLINES-1:0][DATA_W-1:0] data_arr;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    line_st_t          st_q, st_d;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] data_q;
    logic              sel_s, sel_c;

    assign sel_s = sw_en && (sw_idx == IDX_W'(i));
    assign sel_c = cw_en && (cw_idx == IDX_W'(i));

    // snoop update outranks the processor side on the same line
    always_comb begin
      st_d = st_q;
      if (sel_s)      st_d = sw_st;
      else if (sel_c) st_d = cw_st;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= LN_INV;
      else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
      if (sel_c && cw_tag_en)  tag_q  <= cw_tag;
      if (sel_c && cw_data_en) data_q <= cw_data;
    end

    assign st_arr[i]   = st_q;
    assign tag_arr[i]  = tag_q;
    assign data_arr[i] = data_q;
  end

  assign a_st   = line_st_t'(st_arr[a_idx]);
  assign a_tag  = tag_arr[a_idx];
  assign a_data = data_arr[a_idx];
  assign b_st   = line_st_t'(st_arr[b_idx]);
  assign b_tag  = tag_arr[b_idx];
  assign b_data = data_arr[b_idx];
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_snoop_pkg::*;
#(
  parameter int NLINES   = 4,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int AGENT_W  = 2,
  parameter int AGENT_ID = 0,
  localparam int IDX_W = $clog2(NLINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic               snp_valid,
  input  logic [1:0]         snp_cmd,
  input  logic [ADDR_W-1:0]  snp_addr,
  input  logic [AGENT_W-1:0] snp_agent,
  input  line_st_t           ln_st,
  input  logic [TAG_W-1:0]   ln_tag,
  input  logic [DATA_W-1:0]  ln_data,
  output logic [IDX_W-1:0]   s_idx,
  output logic               s_hit,
  output logic               flush,
  output logic [DATA_W-1:0]  flush_data,
  output logic               upd_en,
  output line_st_t           upd_st
);
  logic             foreign, is_rd, is_wr;
  logic [TAG_W-1:0] s_tag;

  assign s_idx   = snp_addr[IDX_W-1:0];
  assign s_tag   = snp_addr[ADDR_W-1:IDX_W];
  assign foreign = snp_valid && (snp_agent != AGENT_W'(AGENT_ID));
  assign is_rd   = (snp_cmd == BC_RDMISS);
  assign is_wr   = (snp_cmd == BC_WRMISS);

  always_comb begin
    s_hit      = foreign && (is_rd || is_wr) && (ln_st != LN_INV) && (ln_tag == s_tag);
    flush      = s_hit && (ln_st == LN_EXC);
    flush_data = flush ? ln_data : '0;
    upd_en     = flush || (s_hit && is_wr);
    upd_st     = (flush && is_rd) ? LN_SHR : LN_INV;
  end
endmodule

// File: rtl/msi_req_unit.sv
module msi_req_unit
  import msi_snoop_pkg::*;
#(
  parameter int NLINES = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(NLINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  line_st_t          ln_st,
  input  logic [TAG_W-1:0]  ln_tag,
  input  logic [DATA_W-1:0] ln_data,
  input  logic              blocked,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_fill,
  output logic [IDX_W-1:0]  c_idx,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output bus_cmd_t          bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              cw_en,
  output line_st_t          cw_st,
  output logic              cw_tag_en,
  output logic [TAG_W-1:0]  cw_tag,
  output logic              cw_data_en,
  output logic [DATA_W-1:0] cw_data
);
  logic [TAG_W-1:0] c_tag;
  logic             present, hit, victim, act;
  bus_cmd_t         want;

  assign c_idx = cpu_addr[IDX_W-1:0];
  assign c_tag = cpu_addr[ADDR_W-1:IDX_W];

  always_comb begin
    present   = (ln_st != LN_INV) && (ln_tag == c_tag);
    hit       = present && (!cpu_we || (ln_st == LN_EXC));
    victim    = (ln_st == LN_EXC) && !present;
    want      = victim ? BC_WRBACK : (cpu_we ? BC_WRMISS : BC_RDMISS);
    cpu_ready = cpu_req && hit && !blocked;
    cpu_rdata = cpu_ready ? ln_data : '0;
    bus_req   = cpu_req && !hit;
    bus_cmd   = bus_req ? want : BC_NONE;
    bus_addr  = victim ? {ln_tag, c_idx} : cpu_addr;
    bus_wdata = (bus_req && victim) ? ln_data : '0;
    act       = bus_req && bus_gnt && !blocked;

    cw_en      = 1'b0;
    cw_st      = LN_INV;
    cw_tag_en  = 1'b0;
    cw_tag     = c_tag;
    cw_data_en = 1'b0;
    cw_data    = bus_fill;
    if (cpu_ready && cpu_we) begin
      cw_en      = 1'b1;
      cw_st      = LN_EXC;
      cw_data_en = 1'b1;
      cw_data    = cpu_wdata;
    end else if (act) begin
      cw_en = 1'b1;
      unique case (want)
        BC_WRBACK: cw_st = LN_INV;
        BC_RDMISS: begin cw_st = LN_SHR; cw_tag_en = 1'b1; cw_data_en = 1'b1; end
        default:   begin cw_st = LN_EXC; cw_tag_en = 1'b1; cw_data_en = 1'b1; end
      endcase
    end
  end
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
  import msi_snoop_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int NLINES   = 4,
  parameter int AGENT_W  = 2,
  parameter int AGENT_ID = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic               cpu_ready,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic               bus_req,
  input  logic               bus_gnt,
  output logic [1:0]         bus_cmd,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_wdata,
  input  logic [DATA_W-1:0]  bus_fill,
  input  logic               snp_valid,
  input  logic [1:0]         snp_cmd,
  input  logic [ADDR_W-1:0]  snp_addr,
  input  logic [AGENT_W-1:0] snp_agent,
  output logic               snp_flush,
  output logic [DATA_W-1:0]  snp_data
);
  localparam int IDX_W = $clog2(NLINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic              rst_n_sync;
  logic [IDX_W-1:0]  c_idx, s_idx;
  line_st_t          a_st, b_st, s_upd_st, cw_st;
  logic [TAG_W-1:0]  a_tag, b_tag, cw_tag;
  logic [DATA_W-1:0] a_data, b_data, cw_data;
  logic              s_hit, s_upd_en, blocked;
  logic              cw_en, cw_tag_en, cw_data_en;
  bus_cmd_t          cmd_e;

  // a snoop touching the processor's index wins this cycle
  assign blocked = s_hit && (s_idx == c_idx);
  assign bus_cmd = cmd_e;

  msi_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  msi_line_store #(.NLINES(NLINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n_sync),
    .a_idx(c_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
    .b_idx(s_idx), .b_st(b_st), .b_tag(b_tag), .b_data(b_data),
    .sw_en(s_upd_en), .sw_idx(s_idx), .sw_st(s_upd_st),
    .cw_en(cw_en), .cw_idx(c_idx), .cw_st(cw_st),
    .cw_tag_en(cw_tag_en), .cw_tag(cw_tag),
    .cw_data_en(cw_data_en), .cw_data(cw_data)
  );

  msi_snoop_unit #(
    .NLINES(NLINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .AGENT_W(AGENT_W), .AGENT_ID(AGENT_ID)
  ) u_snoop (
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_agent(snp_agent),
    .ln_st(b_st), .ln_tag(b_tag), .ln_data(b_data),
    .s_idx(s_idx), .s_hit(s_hit), .flush(snp_flush), .flush_data(snp_data),
    .upd_en(s_upd_en), .upd_st(s_upd_st)
  );

  msi_req_unit #(.NLINES(NLINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .ln_st(a_st), .ln_tag(a_tag), .ln_data(a_data),
    .blocked(blocked), .bus_gnt(bus_gnt), .bus_fill(bus_fill),
    .c_idx(c_idx), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_cmd(cmd_e), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .cw_en(cw_en), .cw_st(cw_st), .cw_tag_en(cw_tag_en), .cw_tag(cw_tag),
    .cw_data_en(cw_data_en), .cw_data(cw_data)
  );
endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk
  import msi_snoop_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int AGENT_W  = 2,
  parameter int AGENT_ID = 0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_req,
  input logic               cpu_we,
  input logic [ADDR_W-1:0]  cpu_addr,
  input logic [DATA_W-1:0]  cpu_wdata,
  input logic               cpu_ready,
  input logic [DATA_W-1:0]  cpu_rdata,
  input logic               bus_req,
  input logic               bus_gnt,
  input logic [1:0]         bus_cmd,
  input logic [DATA_W-1:0]  bus_fill,
  input logic               snp_valid,
  input logic [1:0]         snp_cmd,
  input logic [AGENT_W-1:0] snp_agent,
  input logic               snp_flush
);
  // R4: a completing access never also asks for the bus
  assert_hit_no_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !bus_req);

  // R9: flush only answers a foreign miss
  assert_flush_foreign_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> (snp_valid && (snp_agent != AGENT_W'(AGENT_ID)) &&
                   ((snp_cmd == BC_RDMISS) || (snp_cmd == BC_WRMISS))));

  // R5: a granted write-back is not requested again for the same held access
  assert_wb_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_gnt && bus_req && (bus_cmd == BC_WRBACK)) |=>
      !(bus_req && (bus_cmd == BC_WRBACK) && $stable(cpu_addr)));

  // R2: a granted read miss lets the held read complete next cycle with the fill
  assert_fill_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_gnt && bus_req && (bus_cmd == BC_RDMISS) && !snp_valid) |=>
      (!(cpu_req && !cpu_we && $stable(cpu_addr) && !snp_valid) ||
       (cpu_ready && (cpu_rdata == $past(bus_fill)))));

  // R3: a write hit is visible to a following read of the same address
  assert_wr_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_we) |=>
      (!(cpu_req && !cpu_we && $stable(cpu_addr) && !snp_valid) ||
       (cpu_ready && (cpu_rdata == $past(cpu_wdata)))));

  // R11: grant only answers a request, and never overlaps a foreign transaction
  assert_gnt_atomic_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_gnt |-> (bus_req && !(snp_valid && (snp_agent != AGENT_W'(AGENT_ID)))));
endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .AGENT_W(AGENT_W), .AGENT_ID(AGENT_ID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_fill(bus_fill),
  .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_agent(snp_agent), .snp_flush(snp_flush)
);

// File: tb/msi_snoop_ctrl_bench.sv
module msi_snoop_ctrl_bench;
  localparam logic [1:0] K_NO = 2'd0, K_RD = 2'd1, K_WR = 2'd2, K_WB = 2'd3;
  localparam logic [1:0] PEER = 2'd1, SELF = 2'd0;

  logic        clk, rst_n;
  logic        cpu_req, cpu_we, cpu_ready;
  logic [7:0]  cpu_addr, bus_addr, snp_addr;
  logic [15:0] cpu_wdata, cpu_rdata, bus_wdata, bus_fill, snp_data;
  logic        bus_req, bus_gnt, snp_valid, snp_flush;
  logic [1:0]  bus_cmd, snp_cmd, snp_agent;

  int n_chk = 0, n_fail = 0;
  bit ended = 0;

  msi_snoop_ctrl u_msi_snoop_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_fill(bus_fill), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
    .snp_addr(snp_addr), .snp_agent(snp_agent), .snp_flush(snp_flush), .snp_data(snp_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [15:0] wd;
    logic [15:0] fill;
    logic [1:0]  ncmd;
    logic [1:0]  c0;
    logic [1:0]  c1;
    logic [7:0]  wba;
    logic [15:0] wbd;
    logic [15:0] rd;
  } vec_t;

  localparam vec_t TBL [10] = '{
    '{1'b0, 8'h10, 16'h0000, 16'h1111, 2'd1, K_RD, K_NO, 8'h00, 16'h0000, 16'h1111}, // R1 R2
    '{1'b0, 8'h10, 16'h0000, 16'h0000, 2'd0, K_NO, K_NO, 8'h00, 16'h0000, 16'h1111}, // R4
    '{1'b1, 8'h10, 16'hAAAA, 16'h1111, 2'd1, K_WR, K_NO, 8'h00, 16'h0000, 16'h0000}, // R3
    '{1'b0, 8'h10, 16'h0000, 16'h0000, 2'd0, K_NO, K_NO, 8'h00, 16'h0000, 16'hAAAA}, // R4
    '{1'b1, 8'h10, 16'hBBBB, 16'h0000, 2'd0, K_NO, K_NO, 8'h00, 16'h0000, 16'h0000}, // R4
    '{1'b0, 8'h14, 16'h0000, 16'h2222, 2'd2, K_WB, K_RD, 8'h10, 16'hBBBB, 16'h2222}, // R5
    '{1'b1, 8'h21, 16'h3333, 16'h0000, 2'd1, K_WR, K_NO, 8'h00, 16'h0000, 16'h0000}, // R3
    '{1'b0, 8'h21, 16'h0000, 16'h0000, 2'd0, K_NO, K_NO, 8'h00, 16'h0000, 16'h3333}, // R4
    '{1'b0, 8'h25, 16'h0000, 16'h4444, 2'd2, K_WB, K_RD, 8'h21, 16'h3333, 16'h4444}, // R5
    '{1'b1, 8'h14, 16'h5555, 16'h2222, 2'd1, K_WR, K_NO, 8'h00, 16'h0000, 16'h0000}  // R3
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // One processor access; grants every bus request and checks each command.
  task automatic do_access(input string req, input vec_t v);
    int  seen = 0;
    bit  done = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = v.we; cpu_addr = v.addr; cpu_wdata = v.wd;
    for (int g = 0; g < 6 && !done; g++) begin
      #1;
      if (cpu_ready) begin
        chk(req, "bus transactions", seen, 32'(v.ncmd));
        if (!v.we) chk(req, "read data", cpu_rdata, v.rd);
        done = 1;
        @(posedge clk); @(negedge clk);
        cpu_req = 1'b0;
      end else if (bus_req) begin
        chk(req, "bus command", bus_cmd, (seen == 0) ? v.c0 : v.c1);
        if (bus_cmd == K_WB) begin
          chk(req, "write-back address", bus_addr, v.wba);
          chk(req, "write-back data", bus_wdata, v.wbd);
        end else begin
          chk(req, "miss address", bus_addr, v.addr);
        end
        seen++;
        bus_gnt = 1'b1; bus_fill = v.fill;
        @(posedge clk); @(negedge clk);
        bus_gnt = 1'b0;
      end else begin
        chk(req, "access made no progress", 0, 1);
        @(negedge clk);
      end
    end
    if (!done) begin
      chk(req, "access completed", 0, 1);
      cpu_req = 1'b0;
    end
  endtask

  task automatic snoop(input string req, input logic [1:0] agent, input logic [1:0] cmd,
                       input logic [7:0] addr, input logic exp_fl, input logic [15:0] exp_d);
    @(negedge clk);
    snp_valid = 1'b1; snp_agent = agent; snp_cmd = cmd; snp_addr = addr;
    #1;
    chk(req, "snoop flush", snp_flush, exp_fl);
    if (exp_fl) chk(req, "snoop data", snp_data, exp_d);
    @(posedge clk); @(negedge clk);
    snp_valid = 1'b0;
  endtask

  function automatic vec_t acc(input logic we, input logic [7:0] a, input logic [15:0] wd,
                               input logic [15:0] fill, input logic [1:0] n, input logic [1:0] c0,
                               input logic [15:0] rd);
    return '{we, a, wd, fill, n, c0, K_NO, 8'h00, 16'h0000, rd};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cpu_req = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
    bus_gnt = 0; bus_fill = 0; snp_valid = 0; snp_cmd = 0; snp_addr = 0; snp_agent = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk); #1;
    // R1: idle outputs after reset, and no line can answer a snoop
    chk("R1", "bus_req idle", bus_req, 0);
    chk("R1", "cpu_ready idle", cpu_ready, 0);
    chk("R1", "flush idle", snp_flush, 0);
    snoop("R1", PEER, K_RD, 8'h10, 1'b0, 16'h0);

    for (int k = 0; k < 10; k++) do_access($sformatf("table entry %0d", k), TBL[k]);

    // R7: foreign read miss on Exclusive 0x14 (holds 5555)
    snoop("R7", PEER, K_RD, 8'h14, 1'b1, 16'h5555);
    do_access("R7", acc(1'b0, 8'h14, 16'h0, 16'h0, 2'd0, K_NO, 16'h5555));
    do_access("R7", acc(1'b1, 8'h14, 16'h6666, 16'h5555, 2'd1, K_WR, 16'h0));

    // R6: Shared line keeps its state on a foreign read, drops on a foreign write
    snoop("R7", PEER, K_RD, 8'h14, 1'b1, 16'h6666);
    snoop("R6", PEER, K_RD, 8'h14, 1'b0, 16'h0);
    do_access("R6", acc(1'b0, 8'h14, 16'h0, 16'h0, 2'd0, K_NO, 16'h6666));
    snoop("R6", PEER, K_WR, 8'h14, 1'b0, 16'h0);
    do_access("R6", acc(1'b0, 8'h14, 16'h0, 16'h7777, 2'd1, K_RD, 16'h7777));

    // R8: foreign write miss on Exclusive
    do_access("R8", acc(1'b1, 8'h14, 16'h8888, 16'h7777, 2'd1, K_WR, 16'h0));
    snoop("R8", PEER, K_WR, 8'h14, 1'b1, 16'h8888);
    do_access("R8", acc(1'b0, 8'h14, 16'h0, 16'h9999, 2'd1, K_RD, 16'h9999));

    // R9: own id, other tag and write-backs change nothing
    snoop("R9", SELF, K_WR, 8'h14, 1'b0, 16'h0);
    snoop("R9", PEER, K_WR, 8'h18, 1'b0, 16'h0);
    snoop("R9", PEER, K_WB, 8'h14, 1'b0, 16'h0);
    do_access("R9", acc(1'b0, 8'h14, 16'h0, 16'h0, 2'd0, K_NO, 16'h9999));
    do_access("R9", acc(1'b1, 8'h14, 16'hAAAA, 16'h9999, 2'd1, K_WR, 16'h0));
    snoop("R9", SELF, K_RD, 8'h14, 1'b0, 16'h0);
    do_access("R9", acc(1'b1, 8'h14, 16'hABAB, 16'h0, 2'd0, K_NO, 16'h0));

    // R10: hit and foreign snoop on the same line in the same cycle
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = 8'h14;
    snp_valid = 1; snp_agent = PEER; snp_cmd = K_RD; snp_addr = 8'h14;
    #1;
    chk("R10", "ready during snoop", cpu_ready, 0);
    chk("R10", "flush during hit", snp_flush, 1);
    chk("R10", "flush data", snp_data, 16'hABAB);
    @(posedge clk); @(negedge clk);
    snp_valid = 0;
    #1;
    chk("R10", "ready after snoop", cpu_ready, 1);
    chk("R10", "read data after snoop", cpu_rdata, 16'hABAB);
    @(posedge clk); @(negedge clk);
    cpu_req = 0;
    do_access("R10", acc(1'b1, 8'h14, 16'hCDCD, 16'hABAB, 2'd1, K_WR, 16'h0));

    // R10 / R11: pending write-back rebuilt after a flush cleans the victim
    do_access("R11", acc(1'b1, 8'h02, 16'h1234, 16'h0000, 2'd1, K_WR, 16'h0));
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = 8'h06;
    for (int w = 0; w < 3; w++) begin
      #1;
      chk("R11", "request held", bus_req, 1);
      chk("R11", "no completion before grant", cpu_ready, 0);
      chk("R11", "pending write-back", bus_cmd, K_WB);
      chk("R11", "victim data", bus_wdata, 16'h1234);
      @(negedge clk);
    end
    snp_valid = 1; snp_agent = PEER; snp_cmd = K_RD; snp_addr = 8'h02;
    #1;
    chk("R10", "flush of pending victim", snp_flush, 1);
    chk("R10", "victim flush data", snp_data, 16'h1234);
    @(posedge clk); @(negedge clk);
    snp_valid = 0;
    #1;
    chk("R10", "rebuilt command", bus_cmd, K_RD);
    chk("R10", "rebuilt address", bus_addr, 8'h06);
    bus_gnt = 1; bus_fill = 16'h0606;
    @(posedge clk); @(negedge clk);
    bus_gnt = 0;
    #1;
    chk("R10", "ready after rebuilt miss", cpu_ready, 1);
    chk("R10", "fill data", cpu_rdata, 16'h0606);
    @(posedge clk); @(negedge clk);
    cpu_req = 0;
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule